// File: doc/BRIEF.md
# Multi-Mode Timer/Counter with Two Compare Channels

This block is a timer/counter peripheral with a configurable counter width (8 or 16 bits). A byte-wide register port sets a clock-select code, an optional slow asynchronous count source, a 4-bit mode code and two compare values. The mode code selects one of four behaviours:

- a free-running count up to a fixed maximum,
- clear-on-match, where compare A sets the wrap point,
- fast PWM, where the two compare values become duty thresholds on two outputs,
- an invalid mode that parks the counter.

Interrupt requests leave the block as single-cycle pulses. Compare A, compare B and overflow each have their own pulse output.

The count rate is the system clock, or the rising edges of a synchronised slow clock, divided by a power of two. The clock-select code picks that power from a parameter table. On a 16-bit counter, software first writes the upper byte of a compare value into a shared holding latch. The write of the lower byte then commits both halves in one step and reconfigures the timer.

Top module: `timer_dual_cmp`

## Requirements
- R1: After reset every register, the counter and the prescaler are zero, and all pulse and PWM outputs are low.
- R2: While the clock-select field (address 0, bits 3:0) is zero, the counter keeps its value and no interrupt pulse is raised.
- R3: A nonzero clock-select code s selects a shift k from the default table (s=1:0, 2:1, 3:2, 4:3, 5:6, 6:8, 7:10, others 0). The counter then advances once every 2^k source ticks. The prescaler restarts from zero after every configuration write, so the first advance comes 2^k source ticks after that write.
- R4: When bit 4 of address 0 is set, the source ticks are the rising edges of `slowClk`, seen after a two-stage synchroniser. Otherwise every system clock cycle is a source tick.
- R5: The mode field (address 1, bits 3:0) maps as follows. Mode 0 is free-running with top 255. Mode 3 is free-running with top 2^CNT_W-1. Mode 1 is clear-on-match with top equal to compare A. Mode 2 is fast PWM with top 2^CNT_W-1. Every other code is invalid: it forces the counter to zero and raises no event. On an advance the counter goes to 0 when it is at or above top, and otherwise adds 1.
- R6: In free-running mode with top different from compare A, `irqOvf` pulses for one cycle in the cycle after the advance that wraps the counter. No overflow pulse occurs in clear-on-match, fast PWM or invalid modes.
- R7: In free-running and clear-on-match modes, a compare value that is nonzero and no greater than top makes its pulse output rise for one cycle after the advance taken while the counter equals that value. In clear-on-match mode compare A therefore fires once every compare-A+1 advances.
- R8: A write to address 4 loads the shared high-byte latch. A write to address 2 (compare A) or address 3 (compare B) stores {latch, data} as the full compare value, so both bytes change together.
- R9: In fast PWM mode `pwmA` is high while the counter is below compare A, and `pwmB` is high while it is below compare B; no interrupt pulse is raised. In all other modes both PWM outputs are low.
- R10: A write to addresses 0 to 3 takes no counter advance in that cycle, clears the prescaler and leaves the counter value unchanged.
- R11: `busRdata` combinationally returns, by `busAddr`:
  - 0: {3'b0, slow enable, clock select}
  - 1: mode
  - 2 and 3: low bytes of compare A and compare B
  - 4 and 5: high bytes of compare A and compare B
  - 6 and 7: counter low and high bytes

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busWr | input | 1 | Register write strobe |
| busAddr | input | 3 | Register address for write and read |
| busWdata | input | 8 | Write data |
| busRdata | output | 8 | Read data selected by busAddr |
| slowClk | input | 1 | Slow asynchronous count source |
| irqCmpA | output | 1 | Compare A pulse |
| irqCmpB | output | 1 | Compare B pulse |
| irqOvf | output | 1 | Overflow pulse |
| pwmA | output | 1 | Duty output driven by compare A |
| pwmB | output | 1 | Duty output driven by compare B |

## Verification
Each result has a fixed latency:
- Read data and PWM outputs follow the register state within the same cycle.
- A register write is visible from the cycle after its sampling edge.
- An interrupt pulse is high exactly in the cycle after the edge that took the qualifying advance.
- A slow-clock edge reaches the counter three system edges after the pin rises, because of the synchroniser and edge register.

The reference model in the bench steps at every rising edge with these latencies built in. Its outputs are compared 1 ns after each falling edge, when inputs and outputs are settled. Pulse-count checks over long windows add an end-to-end measure of event rates with a tolerance of one event at the window edges.

// File: rtl/timer_pkg.sv
package timer_pkg;

  typedef enum logic [1:0] {
    KIND_OFF   = 2'd0,
    KIND_FREE  = 2'd1,
    KIND_MATCH = 2'd2,
    KIND_PWM   = 2'd3
  } modeKind_e;

  // Per-cycle strobes and qualifiers from control to datapath
  typedef struct packed {
    logic tick;
    logic hold;
    logic ovfEn;
    logic cmpAEn;
    logic cmpBEn;
    logic pwmEn;
  } tmrStrobe_t;

  localparam logic [2:0] ADDR_CTL    = 3'd0;
  localparam logic [2:0] ADDR_MODE   = 3'd1;
  localparam logic [2:0] ADDR_CMPA   = 3'd2;
  localparam logic [2:0] ADDR_CMPB   = 3'd3;
  localparam logic [2:0] ADDR_HI     = 3'd4;
  localparam logic [2:0] ADDR_CMPBHI = 3'd5;
  localparam logic [2:0] ADDR_CNTLO  = 3'd6;
  localparam logic [2:0] ADDR_CNTHI  = 3'd7;

endpackage

// File: rtl/timer_ctrl.sv
module timer_ctrl
  import timer_pkg::*;
#(
  parameter int          CNT_W       = 16,
  parameter int          SYNC_STAGES = 2,
  parameter logic [63:0] SHIFT_TABLE = 64'h0000_0000_A863_2100,
  parameter logic [47:0] MODE_TABLE  = 48'h0000_0000_0AD1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             busWr,
  input  logic [2:0]       busAddr,
  input  logic [7:0]       busWdata,
  input  logic             slowClk,
  input  logic [CNT_W-1:0] cnt,
  output logic [7:0]       busRdata,
  output logic [CNT_W-1:0] cmpA,
  output logic [CNT_W-1:0] cmpB,
  output logic [CNT_W-1:0] top,
  output tmrStrobe_t       strobe
);

  localparam int               PRE_W    = 16;
  localparam logic [CNT_W-1:0] ALL_ONES = '1;
  localparam logic [CNT_W-1:0] BYTE_MAX = CNT_W'(255);

  logic [3:0]       clkSel;
  logic             slowEn;
  logic [3:0]       modeSel;
  logic [CNT_W-1:0] cmpAReg;
  logic [CNT_W-1:0] cmpBReg;
  logic [7:0]       hiLatch;
  logic [PRE_W-1:0] preCnt;
  logic [SYNC_STAGES-1:0] syncQ;
  logic             slowLast;

  logic             cfgWrite;
  logic [2:0]       modeEntry;
  modeKind_e        kind;
  logic [3:0]       shiftAmt;
  logic [PRE_W-1:0] preMask;
  logic             srcTick;
  logic [CNT_W-1:0] freeMax;
  logic [CNT_W-1:0] topVal;
  logic [15:0]      wideWr;

  // Slow source synchroniser: depth chosen by parameter
  if (SYNC_STAGES == 1) begin : g_sync_one
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) syncQ <= '0;
      else       syncQ <= slowClk;
    end
  end else begin : g_sync_chain
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) syncQ <= '0;
      else       syncQ <= {syncQ[SYNC_STAGES-2:0], slowClk};
    end
  end

  assign cfgWrite  = busWr && (busAddr <= ADDR_CMPB);
  assign wideWr    = {hiLatch, busWdata};
  assign modeEntry = MODE_TABLE[modeSel*3 +: 3];
  assign kind      = modeKind_e'(modeEntry[1:0]);
  assign shiftAmt  = SHIFT_TABLE[clkSel*4 +: 4];
  assign preMask   = (PRE_W'(1) << shiftAmt) - PRE_W'(1);
  assign srcTick   = slowEn ? (syncQ[SYNC_STAGES-1] & ~slowLast) : 1'b1;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      clkSel   <= '0;
      slowEn   <= 1'b0;
      modeSel  <= '0;
      cmpAReg  <= '0;
      cmpBReg  <= '0;
      hiLatch  <= '0;
      preCnt   <= '0;
      slowLast <= 1'b0;
    end else begin
      slowLast <= syncQ[SYNC_STAGES-1];
      if (cfgWrite)     preCnt <= '0;
      else if (srcTick) preCnt <= preCnt + PRE_W'(1);
      if (busWr) begin
        unique case (busAddr)
          ADDR_CTL: begin
            clkSel <= busWdata[3:0];
            slowEn <= busWdata[4];
          end
          ADDR_MODE: modeSel <= busWdata[3:0];
          ADDR_CMPA: cmpAReg <= wideWr[CNT_W-1:0];
          ADDR_CMPB: cmpBReg <= wideWr[CNT_W-1:0];
          ADDR_HI:   hiLatch <= busWdata;
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    freeMax = (modeEntry[2] && CNT_W > 8) ? ALL_ONES : BYTE_MAX;
    unique case (kind)
      KIND_FREE:  topVal = freeMax;
      KIND_MATCH: topVal = cmpAReg;
      KIND_PWM:   topVal = ALL_ONES;
      default:    topVal = '0;
    endcase
  end

  always_comb begin
    strobe.tick   = (clkSel != 4'd0) && srcTick && !cfgWrite &&
                    ((preCnt & preMask) == preMask);
    strobe.hold   = (kind == KIND_OFF);
    strobe.ovfEn  = (kind == KIND_FREE) && (topVal != cmpAReg);
    strobe.cmpAEn = ((kind == KIND_FREE) || (kind == KIND_MATCH)) &&
                    (cmpAReg != '0) && (cmpAReg <= topVal);
    strobe.cmpBEn = ((kind == KIND_FREE) || (kind == KIND_MATCH)) &&
                    (cmpBReg != '0) && (cmpBReg <= topVal);
    strobe.pwmEn  = (kind == KIND_PWM);
  end

  always_comb begin
    unique case (busAddr)
      ADDR_CTL:    busRdata = {3'b000, slowEn, clkSel};
      ADDR_MODE:   busRdata = {4'b0000, modeSel};
      ADDR_CMPA:   busRdata = cmpAReg[7:0];
      ADDR_CMPB:   busRdata = cmpBReg[7:0];
      ADDR_HI:     busRdata = 8'(cmpAReg >> 8);
      ADDR_CMPBHI: busRdata = 8'(cmpBReg >> 8);
      ADDR_CNTLO:  busRdata = cnt[7:0];
      default:     busRdata = 8'(cnt >> 8);
    endcase
  end

  assign cmpA = cmpAReg;
  assign cmpB = cmpBReg;
  assign top  = topVal;

  // R10: a configuration write costs the counter no change in that cycle
  p_write_freezes_r10: assert property (@(posedge clk) disable iff (!rstN)
    (cfgWrite && !strobe.hold) |=> $stable(cnt));

  // R2: a stopped clock select leaves the count untouched
  p_stopped_holds_r2: assert property (@(posedge clk) disable iff (!rstN)
    ((clkSel == 4'd0) && !strobe.hold) |=> $stable(cnt));

endmodule

// File: rtl/timer_datapath.sv
module timer_datapath
  import timer_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  tmrStrobe_t       strobe,
  input  logic [CNT_W-1:0] top,
  input  logic [CNT_W-1:0] cmpA,
  input  logic [CNT_W-1:0] cmpB,
  output logic [CNT_W-1:0] cnt,
  output logic             irqA,
  output logic             irqB,
  output logic             irqOvf,
  output logic             pwmA,
  output logic             pwmB
);

  logic atTop;

  assign atTop = (cnt >= top);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt    <= '0;
      irqA   <= 1'b0;
      irqB   <= 1'b0;
      irqOvf <= 1'b0;
    end else begin
      irqA   <= strobe.tick && strobe.cmpAEn && (cnt == cmpA);
      irqB   <= strobe.tick && strobe.cmpBEn && (cnt == cmpB);
      irqOvf <= strobe.tick && strobe.ovfEn && atTop;
      if (strobe.hold)      cnt <= '0;
      else if (strobe.tick) cnt <= atTop ? '0 : cnt + CNT_W'(1);
    end
  end

  assign pwmA = strobe.pwmEn && (cnt < cmpA);
  assign pwmB = strobe.pwmEn && (cnt < cmpB);

  // R5: an invalid mode parks the counter at zero
  p_hold_zero_r5: assert property (@(posedge clk) disable iff (!rstN)
    strobe.hold |=> (cnt == '0));

  // R9: fast PWM raises no interrupt
  p_pwm_quiet_r9: assert property (@(posedge clk) disable iff (!rstN)
    strobe.pwmEn |=> !(irqA || irqB || irqOvf));

  // R7: compare pulses last one cycle
  p_cmpa_pulse_r7: assert property (@(posedge clk) disable iff (!rstN)
    irqA |=> !irqA);

  // R6: overflow pulse is single and coincides with a wrapped count
  p_ovf_pulse_r6: assert property (@(posedge clk) disable iff (!rstN)
    irqOvf |=> !irqOvf);

  p_ovf_wrapped_r6: assert property (@(posedge clk) disable iff (!rstN)
    irqOvf |-> (cnt == '0));

endmodule

// File: rtl/timer_dual_cmp.sv
module timer_dual_cmp
  import timer_pkg::*;
#(
  parameter int          CNT_W       = 16,
  parameter int          SYNC_STAGES = 2,
  parameter logic [63:0] SHIFT_TABLE = 64'h0000_0000_A863_2100,
  parameter logic [47:0] MODE_TABLE  = 48'h0000_0000_0AD1
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       busWr,
  input  logic [2:0] busAddr,
  input  logic [7:0] busWdata,
  output logic [7:0] busRdata,
  input  logic       slowClk,
  output logic       irqCmpA,
  output logic       irqCmpB,
  output logic       irqOvf,
  output logic       pwmA,
  output logic       pwmB
);

  tmrStrobe_t       strobe;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] cmpA;
  logic [CNT_W-1:0] cmpB;
  logic [CNT_W-1:0] top;

  timer_ctrl #(
    .CNT_W(CNT_W), .SYNC_STAGES(SYNC_STAGES),
    .SHIFT_TABLE(SHIFT_TABLE), .MODE_TABLE(MODE_TABLE)
  ) i_ctrl (
    .clk(clk), .rstN(rstN), .busWr(busWr), .busAddr(busAddr),
    .busWdata(busWdata), .slowClk(slowClk), .cnt(cnt),
    .busRdata(busRdata), .cmpA(cmpA), .cmpB(cmpB), .top(top),
    .strobe(strobe)
  );

  timer_datapath #(.CNT_W(CNT_W)) i_datapath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .top(top),
    .cmpA(cmpA), .cmpB(cmpB), .cnt(cnt),
    .irqA(irqCmpA), .irqB(irqCmpB), .irqOvf(irqOvf),
    .pwmA(pwmA), .pwmB(pwmB)
  );

endmodule

// File: tb/test_timer_dual_cmp.sv
`timescale 1ns/1ps
module test_timer_dual_cmp;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       busWr = 1'b0;
  logic [2:0] busAddr = 3'd6;
  logic [7:0] busWdata = 8'd0;
  logic [7:0] busRdata;
  logic       slowClk = 1'b0;
  logic       irqCmpA, irqCmpB, irqOvf, pwmA, pwmB;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  bit modelOn = 1'b0;
  bit done = 1'b0;
  string phase = "R1 reset";
  int nA = 0, nB = 0, nO = 0;

  timer_dual_cmp i_timer_dual_cmp (
    .clk(clk), .rstN(rstN), .busWr(busWr), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .slowClk(slowClk),
    .irqCmpA(irqCmpA), .irqCmpB(irqCmpB), .irqOvf(irqOvf),
    .pwmA(pwmA), .pwmB(pwmB)
  );

  always #2.5 clk = ~clk;
  always #33 slowClk = ~slowClk;

  // ---------------- behavioural reference model ----------------
  int mClk, mSlowEn, mMode, mCmpA, mCmpB, mHi, mCnt, mPre;
  bit mS1, mS2, mS3, mIrqA, mIrqB, mIrqO;

  function automatic int shiftOf(int s);
    case (s)
      2: return 1;
      3: return 2;
      4: return 3;
      5: return 6;
      6: return 8;
      7: return 10;
      default: return 0;
    endcase
  endfunction

  function automatic int kindOf(int m);   // 0 off, 1 free, 2 match, 3 pwm
    case (m)
      0, 3: return 1;
      1: return 2;
      2: return 3;
      default: return 0;
    endcase
  endfunction

  function automatic int topOf(int m, int ca);
    case (m)
      0: return 255;
      1: return ca;
      2, 3: return 65535;
      default: return 0;
    endcase
  endfunction

  always @(posedge clk) begin
    int kind, tp, sh, wd;
    bit cfgW, base, tick, aEn, bEn, oEn, atTop;
    if (!rstN) begin
      mClk = 0; mSlowEn = 0; mMode = 0; mCmpA = 0; mCmpB = 0; mHi = 0;
      mCnt = 0; mPre = 0; mS1 = 0; mS2 = 0; mS3 = 0;
      mIrqA = 0; mIrqB = 0; mIrqO = 0;
    end else begin
      kind  = kindOf(mMode);
      tp    = topOf(mMode, mCmpA);
      oEn   = (kind == 1) && (tp != mCmpA);
      aEn   = (kind == 1 || kind == 2) && mCmpA != 0 && mCmpA <= tp;
      bEn   = (kind == 1 || kind == 2) && mCmpB != 0 && mCmpB <= tp;
      cfgW  = busWr && (busAddr <= 3);
      base  = mSlowEn ? (mS2 && !mS3) : 1'b1;
      sh    = shiftOf(mClk);
      tick  = (mClk != 0) && base && !cfgW &&
              ((mPre % (1 << sh)) == ((1 << sh) - 1));
      atTop = mCnt >= tp;
      mIrqA = tick && aEn && (mCnt == mCmpA);
      mIrqB = tick && bEn && (mCnt == mCmpB);
      mIrqO = tick && oEn && atTop;
      if (kind == 0)  mCnt = 0;
      else if (tick)  mCnt = atTop ? 0 : mCnt + 1;
      if (cfgW)       mPre = 0;
      else if (base)  mPre = (mPre + 1) % 65536;
      mS3 = mS2; mS2 = mS1; mS1 = slowClk;
      wd = int'(busWdata);
      if (busWr) begin
        case (busAddr)
          3'd0: begin mClk = wd % 16; mSlowEn = (wd / 16) % 2; end
          3'd1: mMode = wd % 16;
          3'd2: mCmpA = mHi * 256 + wd;
          3'd3: mCmpB = mHi * 256 + wd;
          3'd4: mHi = wd;
          default: ;
        endcase
      end
    end
  end

  function automatic logic [7:0] modelRead(logic [2:0] a);
    case (a)
      3'd0: return 8'(mSlowEn * 16 + mClk);
      3'd1: return 8'(mMode);
      3'd2: return 8'(mCmpA % 256);
      3'd3: return 8'(mCmpB % 256);
      3'd4: return 8'(mCmpA / 256);
      3'd5: return 8'(mCmpB / 256);
      3'd6: return 8'(mCnt % 256);
      default: return 8'(mCnt / 256);
    endcase
  endfunction

  // compare on every cycle, 1 ns after the falling edge
  always @(negedge clk) begin
    logic [12:0] got, exp;
    bit pa, pb;
    #1;
    if (modelOn) begin
      pa  = (kindOf(mMode) == 3) && (mCnt < mCmpA);
      pb  = (kindOf(mMode) == 3) && (mCnt < mCmpB);
      got = {irqCmpA, irqCmpB, irqOvf, pwmA, pwmB, busRdata};
      exp = {mIrqA, mIrqB, mIrqO, pa, pb, modelRead(busAddr)};
      total++;
      if (got !== exp) begin
        bad++;
        $display("FAIL %s model mismatch t=%0t got=%h exp=%h", phase, $time, got, exp);
      end
      if (irqCmpA) nA++;
      if (irqCmpB) nB++;
      if (irqOvf)  nO++;
    end
  end

  // ---------------- helpers ----------------
  task automatic check(string req, int got, int exp);
    total++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s got=%0d exp=%0d", req, got, exp);
    end
  endtask

  task automatic checkRange(string req, int got, int lo, int hi);
    total++;
    if (got < lo || got > hi) begin
      bad++;
      $display("FAIL %s got=%0d exp=%0d..%0d", req, got, lo, hi);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [7:0] d);
    busWr = 1'b1; busAddr = a; busWdata = d;
    @(negedge clk);
    busWr = 1'b0; busAddr = 3'd6;
  endtask

  task automatic rd(logic [2:0] a, output int d);
    busAddr = a;
    #2;
    d = int'(busRdata);
    busAddr = 3'd6;
    @(negedge clk);
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clearCounts();
    #1.5;
    nA = 0; nB = 0; nO = 0;
    @(negedge clk);
  endtask

  // watchdog
  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      done = 1'b1;
      bad++;
      total++;
      $display("FAIL watchdog expired at cycle %0d", cyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int v, v2;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    modelOn = 1'b1;
    @(negedge clk);

    phase = "R1 reset state";
    rd(3'd6, v); check("R1 count low", v, 0);
    rd(3'd0, v); check("R1 control", v, 0);
    check("R1 pulses", int'(irqCmpA) + int'(irqCmpB) + int'(irqOvf), 0);

    phase = "R6 R7 free-running 8-bit";
    wr(3'd4, 8'h00); wr(3'd2, 8'h10); wr(3'd3, 8'h80);
    wr(3'd1, 8'd0);  wr(3'd0, 8'd1);
    clearCounts();
    idle(1024);
    checkRange("R6 overflow count", nO, 3, 5);
    checkRange("R7 compare A count", nA, 3, 5);

    phase = "R8 R5 full-width free-running";
    wr(3'd4, 8'h01); wr(3'd2, 8'h20); wr(3'd4, 8'h77);
    rd(3'd4, v); check("R8 compare A high", v, 1);
    rd(3'd5, v); check("R8 compare B high before commit", v, 0);
    wr(3'd3, 8'h05);
    rd(3'd5, v); check("R8 compare B high after commit", v, 8'h77);
    wr(3'd1, 8'd3);
    idle(700);

    phase = "R7 clear-on-match";
    wr(3'd4, 8'h00); wr(3'd2, 8'd5); wr(3'd3, 8'd3); wr(3'd1, 8'd1);
    clearCounts();
    idle(120);
    checkRange("R7 compare A every 6", nA, 19, 21);
    checkRange("R7 compare B once per period", nB, 19, 21);
    check("R6 no overflow in clear-on-match", nO, 0);

    phase = "R3 prescale shift 2";
    wr(3'd2, 8'd7); wr(3'd0, 8'd3);
    clearCounts();
    idle(320);
    checkRange("R3 compare A at /4", nA, 9, 11);

    phase = "R3 prescale shift 10";
    wr(3'd0, 8'd7);
    clearCounts();
    idle(3000);
    check("R3 slow prescale no compare yet", nA, 0);

    phase = "R4 slow source";
    wr(3'd2, 8'd3); wr(3'd0, 8'h11);
    clearCounts();
    idle(800);
    checkRange("R4 compare A on slow edges", nA, 12, 18);

    phase = "R9 fast PWM";
    wr(3'd0, 8'd1); wr(3'd4, 8'h00); wr(3'd2, 8'h40);
    wr(3'd4, 8'h02); wr(3'd3, 8'h00); wr(3'd1, 8'd2);
    clearCounts();
    idle(800);
    check("R9 no pulses in PWM", nA + nB + nO, 0);

    phase = "R5 invalid mode";
    wr(3'd1, 8'd9);
    clearCounts();
    idle(50);
    rd(3'd6, v); check("R5 invalid count low", v, 0);
    rd(3'd7, v); check("R5 invalid count high", v, 0);
    check("R5 invalid no pulses", nA + nB + nO, 0);

    phase = "R2 stopped";
    wr(3'd1, 8'd0);
    idle(30);
    wr(3'd0, 8'd0);
    clearCounts();
    rd(3'd6, v);
    idle(100);
    rd(3'd6, v2);
    check("R2 count held", v2, v);
    check("R2 no pulses", nA + nB + nO, 0);

    phase = "R10 write suppresses advance";
    wr(3'd0, 8'd1);
    idle(5);
    busWr = 1'b1; busAddr = 3'd3; busWdata = 8'h00;
    idle(10);
    busWr = 1'b0; busAddr = 3'd6;
    idle(5);

    phase = "R11 readback";
    for (int a = 0; a < 8; a++) rd(3'(a), v);
    rd(3'd0, v); check("R11 control readback", v, 1);
    rd(3'd1, v); check("R11 mode readback", v, 0);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule